// File: doc/BRIEF.md
# Reciprocal Equal-Precision Frequency Counter

This block measures the frequency of an external square wave with the same relative accuracy across its whole range. A controller raises and lowers a gate request for a preset time, typically between a tenth of a second for fast inputs and about one second for slow ones. The block turns that request into an actual measurement window. The window opens and closes only on rising edges of the measured signal, so it always spans a whole number of input periods. While the window is open, one counter counts reference-clock cycles and a second counter counts input periods.

When the window closes, the block raises a one-cycle completion pulse and holds both counts. Downstream logic computes the frequency as input-count times reference-frequency divided by reference-count. Because the input count carries no plus-or-minus-one error, the relative error does not depend on the input frequency.

The measured signal is sampled by the reference clock through a synchronizer. Its high and low phases must each last at least two reference-clock cycles. A per-counter overflow flag covers windows that are too long for the counter width. A timeout reports a dead input with zero counts.

Top module: `recip_freq_counter`

## Requirements
- R1: After reset, both counts are zero and `done`, `ref_ovf`, `sig_ovf` and `no_signal` are low.
- R2: One clock after a rising edge of `gate_req`, both counts read zero and both overflow flags and `no_signal` are low, whatever the previous result was.
- R3: The window opens on the first detected rising edge of `sig_in` after `gate_req` rises, and closes on the first detected rising edge after `gate_req` falls. `sig_count` equals the number of whole input periods inside the window: K periods when `gate_req` stayed high across K input rising edges.
- R4: `ref_count` equals the number of clock cycles from the opening input edge to the closing input edge, which is K·P for an input of period P clock cycles.
- R5: `done` is high for exactly one clock cycle. The final counts and flags are already valid in that cycle, and the window is closed.
- R6: After `done`, both counts and flags stay unchanged until the next rising edge of `gate_req`, even while `sig_in` keeps toggling.
- R7: A counter that would pass its all-ones value (2^CNT_W − 1) during a window stops at all-ones and sets its own flag: `ref_ovf` for the reference counter, `sig_ovf` for the input counter. The other counter is unaffected.
- R8: If no rising edge of `sig_in` is detected for TIMEOUT_CYC clock cycles while a request is pending or a window is open, the block ends the measurement. `done` rises TIMEOUT_CYC + 2 clock cycles after `gate_req` was applied, both counts read zero, and `no_signal` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, the time base that is counted |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Shaped measured signal, asynchronous to `clk` |
| gate_req | input | 1 | Preset gate request from the controller |
| ref_count | output | CNT_W (32) | Reference cycles inside the window |
| sig_count | output | CNT_W (32) | Input periods inside the window |
| done | output | 1 | One-cycle pulse when a result is ready |
| ref_ovf | output | 1 | Reference counter saturated |
| sig_ovf | output | 1 | Input counter saturated |
| no_signal | output | 1 | Timeout: no input edge arrived |

## Verification
The results fall due at different times after a stimulus:
- The clear is visible one clock after the request rises.
- The window edges trail each raw input rising edge by the synchronizer's two to three cycles.
- `done` and the final counts appear together one clock after the closing edge is detected.
- The timeout result is due exactly TIMEOUT_CYC + 2 cycles after the request is driven.

The bench generates the input itself. It raises and drops the request at three quarters of an input period, far from any input edge, so the expected K and K·P do not depend on the synchronizer's phase. It then samples every output at the falling clock edge in the cycle where each result falls due, and counts cycles explicitly for the timeout case.

// File: rtl/fc_pkg.sv
package fc_pkg;

    // Gate controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_OPEN  = 2'd2
    } fc_state_e;

    // Three-stage input sampler
    typedef struct packed {
        logic meta;
        logic stab;
        logic prev;
    } fc_sync_t;

    // Counter lanes
    localparam int unsigned LANE_REF = 0;
    localparam int unsigned LANE_SIG = 1;
    localparam int unsigned N_LANES  = 2;

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic sig_rise
);

    fc_sync_t sq;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq <= '0;
        end else begin
            sq.meta <= sig_in;
            sq.stab <= sq.meta;
            sq.prev <= sq.stab;
        end
    end

    assign sig_rise = sq.stab & ~sq.prev;

endmodule

// File: rtl/fc_gate_ctl.sv
module fc_gate_ctl
    import fc_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_req,
    input  logic sig_rise,
    output logic gate,
    output logic clr,
    output logic done,
    output logic no_signal
);

    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

    fc_state_e     st;
    logic          req_q;
    logic [TW-1:0] idle_cnt;
    logic          req_rise;
    logic          expired;

    always_comb begin
        req_rise = gate_req & ~req_q;
        expired  = (st != ST_IDLE) && !sig_rise && (idle_cnt == TW'(TIMEOUT_CYC));
        clr      = req_rise | expired;
    end

    assign gate = (st == ST_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            req_q     <= 1'b0;
            idle_cnt  <= '0;
            done      <= 1'b0;
            no_signal <= 1'b0;
        end else begin
            req_q <= gate_req;
            done  <= 1'b0;
            if (req_rise) begin
                st        <= ST_ARMED;
                idle_cnt  <= '0;
                no_signal <= 1'b0;
            end else if (expired) begin
                st        <= ST_IDLE;
                idle_cnt  <= '0;
                done      <= 1'b1;
                no_signal <= 1'b1;
            end else begin
                if (sig_rise) begin
                    idle_cnt <= '0;
                end else if (st != ST_IDLE) begin
                    idle_cnt <= idle_cnt + TW'(1);
                end
                if (sig_rise) begin
                    case (st)
                        ST_ARMED: if (gate_req) st <= ST_OPEN;
                        ST_OPEN: begin
                            if (!gate_req) begin
                                st   <= ST_IDLE;
                                done <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/fc_counter.sv
module fc_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (en) begin
            if (cnt == CMAX) begin
                ovf <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter
    import fc_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic             gate_req,
    output logic [CNT_W-1:0] ref_count,
    output logic [CNT_W-1:0] sig_count,
    output logic             done,
    output logic             ref_ovf,
    output logic             sig_ovf,
    output logic             no_signal
);

    logic                sig_rise;
    logic                gate_w;
    logic                clr_w;
    logic [N_LANES-1:0]  lane_en;
    logic [N_LANES-1:0]  lane_ovf;
    logic [CNT_W-1:0]    lane_val [N_LANES];

    fc_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (sig_in),
        .sig_rise (sig_rise)
    );

    fc_gate_ctl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .gate_req  (gate_req),
        .sig_rise  (sig_rise),
        .gate      (gate_w),
        .clr       (clr_w),
        .done      (done),
        .no_signal (no_signal)
    );

    always_comb begin
        lane_en[LANE_REF] = gate_w;
        lane_en[LANE_SIG] = gate_w & sig_rise;
    end

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        fc_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (clr_w),
            .en  (lane_en[i]),
            .cnt (lane_val[i]),
            .ovf (lane_ovf[i])
        );
    end

    assign ref_count = lane_val[LANE_REF];
    assign sig_count = lane_val[LANE_SIG];
    assign ref_ovf   = lane_ovf[LANE_REF];
    assign sig_ovf   = lane_ovf[LANE_SIG];

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             gate_req,
    input logic             gate,
    input logic             done,
    input logic             ref_ovf,
    input logic             sig_ovf,
    input logic             no_signal,
    input logic [CNT_W-1:0] ref_count,
    input logic [CNT_W-1:0] sig_count
);

    localparam logic [CNT_W-1:0] FULL = '1;

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_closed_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !gate);

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate && !(gate_req && !$past(gate_req))) |=> ($stable(ref_count) && $stable(sig_count)));

    // R7
    ref_sat_chk: assert property (@(posedge clk) disable iff (rst)
        ref_ovf |-> (ref_count == FULL));

    // R7
    sig_sat_chk: assert property (@(posedge clk) disable iff (rst)
        sig_ovf |-> (sig_count == FULL));

    // R8
    nosig_zero_chk: assert property (@(posedge clk) disable iff (rst)
        no_signal |-> (ref_count == '0 && sig_count == '0));

    // R3
    sig_le_ref_chk: assert property (@(posedge clk) disable iff (rst)
        sig_count <= ref_count);

endmodule

bind recip_freq_counter fc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .gate_req  (gate_req),
    .gate      (gate_w),
    .done      (done),
    .ref_ovf   (ref_ovf),
    .sig_ovf   (sig_ovf),
    .no_signal (no_signal),
    .ref_count (ref_count),
    .sig_count (sig_count)
);

// File: tb/recip_freq_counter_tb_top.sv
`timescale 1ns/1ps
module recip_freq_counter_tb_top;

    localparam int unsigned W    = 10;
    localparam int unsigned TO   = 150;
    localparam longint      CMAX = (64'd1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sig_in = 1'b0;
    logic         gate_req = 1'b0;
    logic [W-1:0] ref_count;
    logic [W-1:0] sig_count;
    logic         done;
    logic         ref_ovf;
    logic         sig_ovf;
    logic         no_signal;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  per      = 16;
    int  ph       = 0;
    int  rises    = 0;
    bit  run_sig  = 1'b0;
    bit  finished = 1'b0;

    recip_freq_counter #(.CNT_W(W), .TIMEOUT_CYC(TO)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sig_in    (sig_in),
        .gate_req  (gate_req),
        .ref_count (ref_count),
        .sig_count (sig_count),
        .done      (done),
        .ref_ovf   (ref_ovf),
        .sig_ovf   (sig_ovf),
        .no_signal (no_signal)
    );

    initial forever #4 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: wait for the falling edge, then advance the input generator
    task automatic tick();
        @(negedge clk);
        if (run_sig) begin
            ph = (ph + 1 >= per) ? 0 : ph + 1;
            if (ph == 0) rises++;
            sig_in = (ph < per / 2);
        end else begin
            sig_in = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (5) tick();
        chk("R1 ref_count after reset", ref_count, 0);
        chk("R1 sig_count after reset", sig_count, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 ovf flags after reset", {ref_ovf, sig_ovf}, 0);
        chk("R1 no_signal after reset", no_signal, 0);
        rst = 1'b0;
        tick();
    endtask

    // Window spanning K input periods of P clocks
    task automatic measure(input int P, input int K);
        longint exp_ref = longint'(K) * P;
        longint exp_sig = K;
        int     cyc     = 0;
        logic [W-1:0] hold_r;
        logic [W-1:0] hold_s;
        per = P;
        ph = P / 2;
        run_sig = 1'b1;
        while (ph != (3 * P) / 4) tick();
        gate_req = 1'b1;
        rises = 0;
        tick();
        // R2: cleared one clock after request rise
        chk("R2 ref_count cleared", ref_count, 0);
        chk("R2 sig_count cleared", sig_count, 0);
        chk("R2 flags cleared", {ref_ovf, sig_ovf, no_signal}, 0);
        while (!(rises == K && ph == (3 * P) / 4)) tick();
        gate_req = 1'b0;
        while (!done && cyc < 4 * P) begin
            tick();
            cyc++;
        end
        chk("R5 done seen", done, 1);
        chk("R3 sig_count", sig_count, (exp_sig > CMAX) ? CMAX : exp_sig);
        chk("R4 ref_count", ref_count, (exp_ref > CMAX) ? CMAX : exp_ref);
        chk("R7 ref_ovf", ref_ovf, (exp_ref > CMAX) ? 1 : 0);
        chk("R7 sig_ovf", sig_ovf, (exp_sig > CMAX) ? 1 : 0);
        chk("R8 no_signal low on good input", no_signal, 0);
        hold_r = ref_count;
        hold_s = sig_count;
        tick();
        chk("R5 done single cycle", done, 0);
        repeat (2 * P) tick();
        chk("R6 ref_count held", ref_count, hold_r);
        chk("R6 sig_count held", sig_count, hold_s);
        chk("R6 no further done", done, 0);
    endtask

    task automatic test_no_signal();
        int n = 0;
        run_sig = 1'b0;
        repeat (6) tick();
        gate_req = 1'b1;
        while (!done && n < int'(TO) + 50) begin
            tick();
            n++;
        end
        chk("R8 timeout latency", n, TO + 2);
        chk("R8 ref_count zero", ref_count, 0);
        chk("R8 sig_count zero", sig_count, 0);
        chk("R8 no_signal set", no_signal, 1);
        gate_req = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=completed");
        finish_run();
    end

    initial begin
        test_reset();
        measure(16, 20);
        measure(40, 10);
        measure(100, 5);
        test_no_signal();
        measure(40, 12);     // also R2: no_signal cleared by new request
        measure(16, 70);     // R7: reference counter saturates
        measure(16, 1100);   // R7: both counters saturate
        finish_run();
    end

endmodule